// File: doc/BRIEF.md
# Network Adapter Host Glue Register Block

This block is the byte-wide register interface that a host sees when it talks to a token-ring adapter. It holds a small set of control registers. Through them the host pulses the protocol controller's active-low reset, picks the ring speed and the cable type, and drives an extra high register-select line. It also decides whether the host's level interrupt line follows the controller interrupt.

Host addresses with bit 3 clear fall in an eight-byte window. The window reaches either the protocol controller's system-interface registers or a two-page identification ROM, depending on a control bit. One ROM page carries the manufacturer ID, card type, revision and copies of three bus configuration bytes. The other page carries the six-byte burned-in station address.

The controller's level interrupt sets a sticky latch, and the host can test that latch with a single byte read. The host clears the latch by writing its interrupt-enable bit inverted and then writing it back. An interrupt that is still asserted sets the latch again on the cycle after the clear, so a pending request is not lost.

Top module: `nic_glue_regs`

## Requirements
- R1: After reset, the registers at address 8 (CR0), 9 (CR1) and 15 (CR7) read 0x00, `ctl_rst_n` is low, and `host_irq`, `ring_16m`, `ctl_rs_hi` and `cable_utp` are low.
- R2: Writes take effect at the clock edge on which `bus_we` is high. CR1 and CR7 read back all 8 bits last written. CR0 reads back bits 7..1 last written. Reads are combinational from `bus_addr`.
- R3: The interrupt latch sets on any clock edge at which `ctl_irq` is high, unless a clear happens on that same edge. It stays set after `ctl_irq` falls, and it reads as CR0 bit 0.
- R4: `host_irq` is high exactly when the latch is set and CR1 bit 1 (interrupt enable) is set.
- R5: A CR1 write that changes the value of bit 1 clears the latch at that edge. A CR1 write that leaves bit 1 unchanged does not clear it. If `ctl_irq` is still high, the latch sets again on the next edge.
- R6: With CR0 bit 2 set, a window access (address 0..7) reaches the controller. `ctl_rd` or `ctl_wr` follows `bus_rd` or `bus_we`, `ctl_addr` is address bits 2..0, and `bus_rdata` returns `ctl_rdata`.
- R7: With CR0 bit 2 clear, window reads return ROM data, `ctl_rd` and `ctl_wr` stay low, and window writes change nothing in the controller.
- R8: ROM page 0 (CR0 bit 3 clear) returns the following bytes. Byte 0 is 0x4D. Byte 1 is the card type (default 0x08). Byte 2 is the revision (default 0x03). Bytes 3, 4 and 5 are `bus_cfg[7:0]`, `bus_cfg[15:8]` and `bus_cfg[23:16]`. Bytes 6 and 7 are 0x00.
- R9: ROM page 1 (CR0 bit 3 set) returns the station address in bytes 1 to 6, most significant byte first. Bytes 0 and 7 read 0x00.
- R10: CR1 bit 0 drives `ctl_rst_n`, bit 2 drives `ring_16m` (1 = 16 Mb/s), and bit 3 drives `ctl_rs_hi`.
- R11: CR7 bit 0 drives `cable_utp` (1 = UTP, 0 = STP).
- R12: Writing CR0 bit 0 has no effect: the interrupt status read back depends only on the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Host byte address |
| bus_we | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| bus_cfg | input | 24 | Three bus configuration bytes mirrored in ROM page 0 |
| ctl_irq | input | 1 | Controller level interrupt |
| ctl_rdata | input | 8 | Controller register read data |
| ctl_rd | output | 1 | Controller register read strobe |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_addr | output | 3 | Controller register offset |
| ctl_wdata | output | 8 | Controller register write data |
| ctl_rst_n | output | 1 | Controller active-low reset |
| ctl_rs_hi | output | 1 | Controller top register-select line |
| ring_16m | output | 1 | Ring speed select |
| cable_utp | output | 1 | Cable type select |
| host_irq | output | 1 | Gated interrupt to host |

## Verification
The assertions check the interrupt latch on every cycle. They check that it sets while the input is high, that it holds until a clear, that a write toggling the enable bit clears it, and that the host line never rises without it. On every cycle they also check that no controller strobe appears while the ROM is mapped. The bench scenarios are needed to show the ROM byte values on both pages, the register readback and output bit assignments, and that a window write made while unmapped leaves controller contents untouched. They also show the set-again-after-clear timing with a held interrupt.

// File: rtl/nic_glue_regs.sv
module nic_glue_regs #(
  parameter logic [7:0]  MFR_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  REVISION  = 8'h03,
  parameter logic [47:0] STATION   = 48'h0000F5_123456
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [23:0] bus_cfg,
  input  logic        ctl_irq,
  input  logic [7:0]  ctl_rdata,
  output logic        ctl_rd,
  output logic        ctl_wr,
  output logic [2:0]  ctl_addr,
  output logic [7:0]  ctl_wdata,
  output logic        ctl_rst_n,
  output logic        ctl_rs_hi,
  output logic        ring_16m,
  output logic        cable_utp,
  output logic        host_irq
);
  localparam logic [3:0] A_CR0 = 4'h8;
  localparam logic [3:0] A_CR1 = 4'h9;
  localparam logic [3:0] A_CR7 = 4'hF;

  logic [7:1] cr0;
  logic [7:0] cr1, cr7;
  logic       irq_lat;
  logic [7:0] rom_byte;

  wire in_win   = ~bus_addr[3];
  wire map_ctl  = cr0[2];
  wire rom_page = cr0[3];
  wire wr_cr1   = bus_we && bus_addr == A_CR1;
  wire irq_clr  = wr_cr1 && (bus_wdata[1] != cr1[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0 <= '0;
      cr1 <= '0;
      cr7 <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CR0) cr0 <= bus_wdata[7:1];
      if (bus_addr == A_CR1) cr1 <= bus_wdata;
      if (bus_addr == A_CR7) cr7 <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_lat <= 1'b0;
    else if (irq_clr) irq_lat <= 1'b0;
    else if (ctl_irq) irq_lat <= 1'b1;
  end

  always_comb begin
    rom_byte = 8'h00;
    if (!rom_page) begin
      case (bus_addr[2:0])
        3'd0: rom_byte = MFR_ID;
        3'd1: rom_byte = CARD_TYPE;
        3'd2: rom_byte = REVISION;
        3'd3: rom_byte = bus_cfg[7:0];
        3'd4: rom_byte = bus_cfg[15:8];
        3'd5: rom_byte = bus_cfg[23:16];
        default: rom_byte = 8'h00;
      endcase
    end else begin
      case (bus_addr[2:0])
        3'd1: rom_byte = STATION[47:40];
        3'd2: rom_byte = STATION[39:32];
        3'd3: rom_byte = STATION[31:24];
        3'd4: rom_byte = STATION[23:16];
        3'd5: rom_byte = STATION[15:8];
        3'd6: rom_byte = STATION[7:0];
        default: rom_byte = 8'h00;
      endcase
    end
  end

  always_comb begin
    if (in_win)                 bus_rdata = map_ctl ? ctl_rdata : rom_byte;
    else if (bus_addr == A_CR0) bus_rdata = {cr0, irq_lat};
    else if (bus_addr == A_CR1) bus_rdata = cr1;
    else if (bus_addr == A_CR7) bus_rdata = cr7;
    else                        bus_rdata = 8'h00;
  end

  assign ctl_rd    = bus_rd && in_win && map_ctl;
  assign ctl_wr    = bus_we && in_win && map_ctl;
  assign ctl_addr  = bus_addr[2:0];
  assign ctl_wdata = bus_wdata;
  assign ctl_rst_n = cr1[0];
  assign ring_16m  = cr1[2];
  assign ctl_rs_hi = cr1[3];
  assign cable_utp = cr7[0];
  assign host_irq  = irq_lat && cr1[1];
endmodule

// File: rtl/nic_glue_regs_chk.sv
module nic_glue_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic       wen_bit,
  input logic       ctl_irq,
  input logic       ctl_rd,
  input logic       ctl_wr,
  input logic       host_irq,
  input logic       irq_lat,
  input logic       en_q,
  input logic       map_q
);
  wire cr1_wr = bus_we && bus_addr == 4'h9;

  assert_irq_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_irq && !cr1_wr) |=> irq_lat);

  assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lat && !cr1_wr) |=> irq_lat);

  assert_toggle_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1_wr && wen_bit != en_q) |=> !irq_lat);

  assert_host_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (irq_lat && en_q));

  assert_rom_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !map_q |-> (!ctl_rd && !ctl_wr));
endmodule

bind nic_glue_regs nic_glue_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wen_bit(bus_wdata[1]), .ctl_irq(ctl_irq), .ctl_rd(ctl_rd),
  .ctl_wr(ctl_wr), .host_irq(host_irq), .irq_lat(irq_lat),
  .en_q(cr1[1]), .map_q(cr0[2])
);

// File: tb/sim_nic_glue_regs.sv
`timescale 1ns/1ps
module sim_nic_glue_regs;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [23:0] bus_cfg = 24'hC3B2A1;
  logic ctl_irq = 0;
  logic [7:0] ctl_rdata;
  logic ctl_rd, ctl_wr, ctl_rst_n, ctl_rs_hi, ring_16m, cable_utp, host_irq;
  logic [2:0] ctl_addr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_mem [8];
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nic_glue_regs u0 (.*);

  always_ff @(posedge clk) if (ctl_wr) ctl_mem[ctl_addr] <= ctl_wdata;
  assign ctl_rdata = ctl_mem[ctl_addr];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a; bus_rd = 1; #1;
    chk(tag, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 cr0", 4'h8, 8'h00);
    rd_chk("R1 cr1", 4'h9, 8'h00);
    rd_chk("R1 cr7", 4'hF, 8'h00);
    chk("R1 outs", {ctl_rst_n, host_irq, ring_16m, ctl_rs_hi, cable_utp}, 8'h00);
  endtask

  task automatic t_ctrl1;
    wr(4'h9, 8'hCD);
    rd_chk("R2 cr1 readback", 4'h9, 8'hCD);
    chk("R10 rst/speed/rs", {ctl_rst_n, ring_16m, ctl_rs_hi}, 8'h07);
    wr(4'h9, 8'h01);
    chk("R10 speed4 rs0", {ctl_rst_n, ring_16m, ctl_rs_hi}, 8'h04);
    wr(4'h9, 8'h00);
    chk("R10 reset low", ctl_rst_n, 8'h00);
    wr(4'h9, 8'h01);
    chk("R10 reset released", ctl_rst_n, 8'h01);
  endtask

  task automatic t_cable;
    wr(4'hF, 8'h01);
    chk("R11 utp", cable_utp, 8'h01);
    wr(4'hF, 8'hA0);
    chk("R11 stp", cable_utp, 8'h00);
    rd_chk("R2 cr7 readback", 4'hF, 8'hA0);
  endtask

  task automatic t_rom;
    wr(4'h8, 8'h00);
    rd_chk("R8 mfr", 4'h0, 8'h4D);
    rd_chk("R8 type", 4'h1, 8'h08);
    rd_chk("R8 rev", 4'h2, 8'h03);
    rd_chk("R8 cfg0", 4'h3, 8'hA1);
    rd_chk("R8 cfg1", 4'h4, 8'hB2);
    rd_chk("R8 cfg2", 4'h5, 8'hC3);
    rd_chk("R8 b6", 4'h6, 8'h00);
    bus_addr = 4'h2; bus_rd = 1; #1;
    chk("R7 no ctl_rd", ctl_rd, 8'h00);
    bus_rd = 0;
    wr(4'h8, 8'h08);
    rd_chk("R9 b0", 4'h0, 8'h00);
    rd_chk("R9 b1", 4'h1, 8'h00);
    rd_chk("R9 b2", 4'h2, 8'h00);
    rd_chk("R9 b3", 4'h3, 8'hF5);
    rd_chk("R9 b4", 4'h4, 8'h12);
    rd_chk("R9 b5", 4'h5, 8'h34);
    rd_chk("R9 b6", 4'h6, 8'h56);
    rd_chk("R9 b7", 4'h7, 8'h00);
    wr(4'h3, 8'hFF);
  endtask

  task automatic t_map;
    wr(4'h8, 8'hF5);
    rd_chk("R12 cr0 bit0 ignored", 4'h8, 8'hF4);
    wr(4'h8, 8'h04);
    rd_chk("R2 cr0 readback", 4'h8, 8'h04);
    rd_chk("R7 unmapped write ignored", 4'h3, 8'h13);
    wr(4'h2, 8'h5A);
    rd_chk("R6 ctl write/read", 4'h2, 8'h5A);
    bus_addr = 4'h5; bus_rd = 1; #1;
    chk("R6 ctl_rd strobe", ctl_rd, 8'h01);
    chk("R6 ctl data", bus_rdata, 8'h15);
    bus_rd = 0;
  endtask

  task automatic t_irq;
    wr(4'h9, 8'h03);
    rd_chk("R3 idle", 4'h8, 8'h04);
    @(negedge clk); ctl_irq = 1;
    @(negedge clk); ctl_irq = 0;
    rd_chk("R3 latched", 4'h8, 8'h05);
    chk("R4 host on", host_irq, 8'h01);
    repeat (3) @(negedge clk);
    rd_chk("R3 sticky", 4'h8, 8'h05);
    wr(4'h9, 8'h03);
    rd_chk("R5 same-value write keeps", 4'h8, 8'h05);
    wr(4'h9, 8'h01);
    rd_chk("R5 toggle clears", 4'h8, 8'h04);
    chk("R4 host off when disabled", host_irq, 8'h00);
    @(negedge clk); ctl_irq = 1;
    @(negedge clk); #1;
    chk("R4 latched but disabled", host_irq, 8'h00);
    wr(4'h9, 8'h03);
    rd_chk("R5 cleared under held irq", 4'h8, 8'h04);
    @(negedge clk);
    rd_chk("R5 sets again", 4'h8, 8'h05);
    chk("R4 host on again", host_irq, 8'h01);
    ctl_irq = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ctl_mem[i] = 8'h10 + 8'(i);
    #1; t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ctrl1;
    t_cable;
    t_rom;
    t_map;
    t_irq;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule